// File: doc/BRIEF.md
# Hash Context Save/Restore Port

This block sits beside a hash engine and holds the engine's chaining state and running message length in a register file that software reaches over a plain 32-bit register bus. Software moves the state through a single data address that steps an internal word pointer on every access. To save a context, software reads that address repeatedly. To restore one, software writes it repeatedly, then writes the two length words. After a job finishes, the first words of the same store hold the digest. A 224-bit digest uses 7 words, 256 bits use 8, 384 bits use 12, and 512 bits use 16.

How many words the pointer cycles through depends on the algorithm code in the mode register. The mode register also holds a keyed-hash enable and a data-write endianness field. A status register mirrors the engine's busy line. While the engine is busy, software accesses to the state are blocked. The hash compression logic is outside this block. It is represented here by a busy input and a word-load port, through which the engine deposits results.

Top module: `hash_ctx_port`

## Requirements
- R1: After reset the mode register reads 0xA800_0000 (endianness field 0x2A, algorithm code 0, keyed-hash off), every chain word reads 0, both length words read 0 and the word pointer is 0.
- R2: The mode register (offset 0x00) keeps only the algorithm code in bits 18:16, the keyed-hash enable in bit 22 and the endianness field in bits 31:26; all other bits read back 0.
- R3: Algorithm codes 0, 1 and 4 give a word count of 8, and codes 2 and 3 give 16. Codes 5 to 7 are stored but give a count of 0. With a count of 0, chain data accesses neither change state nor move the pointer, and they read 0.
- R4: A write to the chain data address (offset 0x04) stores into the word at the pointer and advances the pointer. After the last word of the count, the pointer wraps to 0.
- R5: A read of the chain data address returns the word at the pointer and advances the same pointer, with the same wrap rule.
- R6: Any accepted write to the mode register returns the pointer to 0.
- R7: Status (offset 0x58) bit 0 equals the busy input and the other bits read 0. While busy is high, all register writes are ignored and all reads other than status return 0. The pointer does not move while busy is high.
- R8: The message length low word (offset 0x60) and high word (offset 0x64) are written and read back independently.
- R9: A strobe on the engine load port writes the given word index directly, whether or not busy is high, and the new word is then readable through the chain data address.
- R10: Reads of unmapped offsets return 0, and writes to them change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the strobe cycle |
| busy_i | input | 1 | Engine busy |
| eng_we_i | input | 1 | Engine word load strobe |
| eng_idx_i | input | 4 | Engine word index |
| eng_data_i | input | 32 | Engine word value |
| alg_o | output | 3 | Algorithm code |
| hmac_en_o | output | 1 | Keyed-hash enable |
| endian_o | output | 6 | Endianness field |
| word_cnt_o | output | 5 | State words for the current algorithm |
| chain_o | output | 512 | All chain words, word 0 in the low bits |
| msg_len_o | output | 64 | Message length, {high, low} |

## Verification
The bench builds the block with its default values: 8 short-mode words, 16 long-mode words, 32-bit words and a 12-bit offset space. These values bring both wrap points of the pointer within reach, along with the zero-count codes 5 to 7 in the 3-bit code field. Random sequences mix mode changes between the short, long and unsupported counts with busy windows, engine loads at every index and unmapped accesses. As a result, the pointer is exercised from arbitrary positions rather than only from 0.

// File: rtl/hash_ctx_pkg.sv
package hash_ctx_pkg;
  localparam int ALG_W      = 3;
  localparam int ALG_LSB    = 16;
  localparam int HMAC_BIT   = 22;
  localparam int ENDIAN_W   = 6;
  localparam int ENDIAN_LSB = 26;
  localparam logic [ENDIAN_W-1:0] ENDIAN_RST = 6'h2A;

  typedef enum logic [ALG_W-1:0] {
    ALG_SHA256 = 3'd0,
    ALG_SHA224 = 3'd1,
    ALG_SHA384 = 3'd2,
    ALG_SHA512 = 3'd3,
    ALG_SM3    = 3'd4
  } hash_alg_e;
endpackage

// File: rtl/hash_ctx_mode_reg.sv
module hash_ctx_mode_reg
  import hash_ctx_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SHORT_WORDS = 8,
  parameter int LONG_WORDS  = 16,
  localparam int CNT_W      = $clog2(LONG_WORDS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   mode_o,
  output logic [ALG_W-1:0]    alg_o,
  output logic                hmac_en_o,
  output logic [ENDIAN_W-1:0] endian_o,
  output logic [CNT_W-1:0]    word_cnt_o
);
  logic [ALG_W-1:0]    alg_q;
  logic                hmac_q;
  logic [ENDIAN_W-1:0] endian_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alg_q    <= '0;
      hmac_q   <= 1'b0;
      endian_q <= ENDIAN_RST;
    end else if (wr_i) begin
      alg_q    <= wdata_i[ALG_LSB +: ALG_W];
      hmac_q   <= wdata_i[HMAC_BIT];
      endian_q <= wdata_i[ENDIAN_LSB +: ENDIAN_W];
    end
  end

  always_comb begin
    mode_o = '0;
    mode_o[ALG_LSB +: ALG_W]       = alg_q;
    mode_o[HMAC_BIT]               = hmac_q;
    mode_o[ENDIAN_LSB +: ENDIAN_W] = endian_q;
  end

  // unsupported codes stay stored but expose no state words
  always_comb begin
    case (alg_q)
      ALG_SHA256, ALG_SHA224, ALG_SM3: word_cnt_o = CNT_W'(SHORT_WORDS);
      ALG_SHA384, ALG_SHA512:          word_cnt_o = CNT_W'(LONG_WORDS);
      default:                         word_cnt_o = '0;
    endcase
  end

  assign alg_o     = alg_q;
  assign hmac_en_o = hmac_q;
  assign endian_o  = endian_q;

  assert_mode_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (alg_o == $past(wdata_i[ALG_LSB +: ALG_W])) && (hmac_en_o == $past(wdata_i[HMAC_BIT])));
endmodule

// File: rtl/hash_ctx_chain_store.sv
module hash_ctx_chain_store #(
  parameter int DATA_W   = 32,
  parameter int WORDS    = 16,
  localparam int IDX_W   = $clog2(WORDS),
  localparam int CNT_W   = $clog2(WORDS + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    step_i,
  input  logic                    wr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic                    eng_we_i,
  input  logic [IDX_W-1:0]        eng_idx_i,
  input  logic [DATA_W-1:0]       eng_data_i,
  output logic [DATA_W-1:0]       rd_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic [WORDS*DATA_W-1:0] chain_o
);
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] word_q [WORDS];
  logic              at_last;

  assign at_last = (CNT_W'(idx_q) + CNT_W'(1)) >= cnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (clr_i)   idx_q <= '0;
    else if (step_i)  idx_q <= at_last ? '0 : idx_q + IDX_W'(1);
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic sel_eng, sel_bus;
    assign sel_eng = eng_we_i && (eng_idx_i == IDX_W'(g));
    assign sel_bus = wr_i && step_i && (idx_q == IDX_W'(g));
    // engine load wins a same-cycle clash
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      word_q[g] <= '0;
      else if (sel_eng) word_q[g] <= eng_data_i;
      else if (sel_bus) word_q[g] <= wdata_i;
    end
    assign chain_o[g*DATA_W +: DATA_W] = word_q[g];
  end

  assign rd_o  = word_q[idx_q];
  assign idx_o = idx_q;

  assert_idx_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q == '0) || (CNT_W'(idx_q) < cnt_i));
  assert_idx_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (idx_q == '0));
  assert_idx_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !step_i) |=> $stable(idx_q));
endmodule

// File: rtl/hash_ctx_len_reg.sv
module hash_ctx_len_reg #(
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_lo_i,
  input  logic                wr_hi_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [2*DATA_W-1:0] len_o
);
  logic [1:0] wr_v;
  assign wr_v = {wr_hi_i, wr_lo_i};

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [DATA_W-1:0] half_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      half_q <= '0;
      else if (wr_v[h]) half_q <= wdata_i;
    end
    assign len_o[h*DATA_W +: DATA_W] = half_q;
  end

  assert_len_lo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> (len_o[DATA_W-1:0] == $past(wdata_i)));
  assert_len_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_lo_i && !wr_hi_i) |=> $stable(len_o));
endmodule

// File: rtl/hash_ctx_port.sv
module hash_ctx_port
  import hash_ctx_pkg::*;
#(
  parameter int DATA_W         = 32,
  parameter int ADDR_W         = 12,
  parameter int SHORT_WORDS    = 8,
  parameter int LONG_WORDS     = 16,
  parameter logic [11:0] OFF_MODE   = 12'h000,
  parameter logic [11:0] OFF_CHAIN  = 12'h004,
  parameter logic [11:0] OFF_STATUS = 12'h058,
  parameter logic [11:0] OFF_LEN_LO = 12'h060,
  parameter logic [11:0] OFF_LEN_HI = 12'h064,
  localparam int IDX_W = $clog2(LONG_WORDS),
  localparam int CNT_W = $clog2(LONG_WORDS + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            rdata_o,
  input  logic                         busy_i,
  input  logic                         eng_we_i,
  input  logic [IDX_W-1:0]             eng_idx_i,
  input  logic [DATA_W-1:0]            eng_data_i,
  output logic [ALG_W-1:0]             alg_o,
  output logic                         hmac_en_o,
  output logic [ENDIAN_W-1:0]          endian_o,
  output logic [CNT_W-1:0]             word_cnt_o,
  output logic [LONG_WORDS*DATA_W-1:0] chain_o,
  output logic [2*DATA_W-1:0]          msg_len_o
);
  logic hit_mode, hit_chain, hit_status, hit_lo, hit_hi;
  logic wr_ok, chain_step;
  logic [DATA_W-1:0] mode_rd, chain_rd;
  logic [IDX_W-1:0]  idx;

  assign hit_mode   = addr_i == ADDR_W'(OFF_MODE);
  assign hit_chain  = addr_i == ADDR_W'(OFF_CHAIN);
  assign hit_status = addr_i == ADDR_W'(OFF_STATUS);
  assign hit_lo     = addr_i == ADDR_W'(OFF_LEN_LO);
  assign hit_hi     = addr_i == ADDR_W'(OFF_LEN_HI);

  assign wr_ok      = req_i && we_i && !busy_i;
  assign chain_step = req_i && hit_chain && !busy_i && (word_cnt_o != '0);

  hash_ctx_mode_reg #(
    .DATA_W(DATA_W), .SHORT_WORDS(SHORT_WORDS), .LONG_WORDS(LONG_WORDS)
  ) u_mode (
    .clk_i, .rst_ni,
    .wr_i      (wr_ok && hit_mode),
    .wdata_i,
    .mode_o    (mode_rd),
    .alg_o, .hmac_en_o, .endian_o, .word_cnt_o
  );

  hash_ctx_chain_store #(.DATA_W(DATA_W), .WORDS(LONG_WORDS)) u_chain (
    .clk_i, .rst_ni,
    .clr_i     (wr_ok && hit_mode),
    .step_i    (chain_step),
    .wr_i      (we_i),
    .wdata_i,
    .cnt_i     (word_cnt_o),
    .eng_we_i, .eng_idx_i, .eng_data_i,
    .rd_o      (chain_rd),
    .idx_o     (idx),
    .chain_o
  );

  hash_ctx_len_reg #(.DATA_W(DATA_W)) u_len (
    .clk_i, .rst_ni,
    .wr_lo_i   (wr_ok && hit_lo),
    .wr_hi_i   (wr_ok && hit_hi),
    .wdata_i,
    .len_o     (msg_len_o)
  );

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (hit_status)      rdata_o[0] = busy_i;
      else if (!busy_i) begin
        if (hit_mode)       rdata_o = mode_rd;
        else if (hit_chain) rdata_o = (word_cnt_o != '0) ? chain_rd : '0;
        else if (hit_lo)    rdata_o = msg_len_o[DATA_W-1:0];
        else if (hit_hi)    rdata_o = msg_len_o[2*DATA_W-1:DATA_W];
      end
    end
  end

  assert_cnt_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_cnt_o == '0) || (word_cnt_o == CNT_W'(SHORT_WORDS)) || (word_cnt_o == CNT_W'(LONG_WORDS)));
  assert_busy_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(msg_len_o) && $stable(alg_o) && $stable(endian_o) && $stable(idx)));
  assert_status_bit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && hit_status) |-> (rdata_o == DATA_W'(busy_i)));
  assert_zero_cnt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_cnt_o == '0) |-> (idx == '0));
endmodule

// File: tb/hash_ctx_port_test.sv
module hash_ctx_port_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_MODE = 12'h000, A_CHAIN = 12'h004, A_STAT = 12'h058,
                          A_LO = 12'h060, A_HI = 12'h064;
  localparam logic [31:0] MODE_MASK = 32'hFC47_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, busy = 1'b0, eng_we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata, eng_data = '0;
  logic [3:0] eng_idx = '0;
  logic [2:0] alg;
  logic hmac_en;
  logic [5:0] endian;
  logic [4:0] word_cnt;
  logic [511:0] chain;
  logic [63:0] msg_len;

  hash_ctx_port uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .busy_i(busy), .eng_we_i(eng_we),
    .eng_idx_i(eng_idx), .eng_data_i(eng_data), .alg_o(alg), .hmac_en_o(hmac_en),
    .endian_o(endian), .word_cnt_o(word_cnt), .chain_o(chain), .msg_len_o(msg_len)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_chain [16];
  logic [31:0] m_mode = 32'hA800_0000;
  logic [63:0] m_len = '0;
  int m_idx = 0;
  logic m_busy = 1'b0;

  function automatic int exp_cnt(logic [31:0] mode);
    case (mode[18:16])
      3'd0, 3'd1, 3'd4: return 8;
      3'd2, 3'd3:       return 16;
      default:          return 0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    int c;
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
    c = exp_cnt(m_mode);
    if (!m_busy) begin
      if (a == A_MODE) begin m_mode = d & MODE_MASK; m_idx = 0; end
      else if (a == A_CHAIN && c != 0) begin m_chain[m_idx] = d; m_idx = (m_idx + 1) % c; end
      else if (a == A_LO) m_len[31:0] = d;
      else if (a == A_HI) m_len[63:32] = d;
    end
  endtask

  task automatic bus_rd(logic [11:0] a, string tag_in);
    logic [31:0] exp;
    string tag;
    int c;
    c = exp_cnt(m_mode);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1;
    exp = '0; tag = "R10";
    if (a == A_STAT) begin exp = {31'b0, m_busy}; tag = "R7"; end
    else if (m_busy) begin
      if (a == A_MODE || a == A_CHAIN || a == A_LO || a == A_HI) tag = "R7";
    end
    else if (a == A_MODE) begin exp = m_mode; tag = "R2"; end
    else if (a == A_CHAIN) begin
      if (c == 0) tag = "R3";
      else begin exp = m_chain[m_idx]; tag = "R5"; end
    end
    else if (a == A_LO) begin exp = m_len[31:0]; tag = "R8"; end
    else if (a == A_HI) begin exp = m_len[63:32]; tag = "R8"; end
    if (tag_in != "") tag = tag_in;
    check(tag, rdata, exp);
    @(posedge clk); #1;
    req = 1'b0;
    if (a == A_CHAIN && !m_busy && c != 0) m_idx = (m_idx + 1) % c;
  endtask

  task automatic eng_wr(logic [3:0] i, logic [31:0] d);
    @(negedge clk);
    eng_we = 1'b1; eng_idx = i; eng_data = d;
    @(posedge clk); #1;
    eng_we = 1'b0;
    m_chain[i] = d;
  endtask

  task automatic set_busy(logic b);
    @(negedge clk);
    busy = b; m_busy = b;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) m_chain[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(A_MODE, "R1");
    for (int i = 0; i < 8; i++) bus_rd(A_CHAIN, "R1");
    bus_rd(A_LO, "R1");
    bus_rd(A_HI, "R1");
    check("R1", {27'b0, word_cnt}, 32'd8);

    // R2 masking, R3 unsupported code stored with zero count
    bus_wr(A_MODE, 32'hFFFF_FFFF);
    bus_rd(A_MODE, "R2");
    check("R3", {27'b0, word_cnt}, 32'd0);
    bus_wr(A_CHAIN, 32'hDEAD_BEEF);
    bus_rd(A_CHAIN, "R3");
    bus_wr(A_MODE, 32'hA800_0000);
    bus_rd(A_CHAIN, "R3");

    // R4 wrap on 8-word count
    for (int i = 0; i < 9; i++) bus_wr(A_CHAIN, 32'h1000_0000 + i);
    for (int i = 0; i < 8; i++) bus_rd(A_CHAIN, "R4");

    // R6 pointer reset by mode write
    bus_wr(A_CHAIN, 32'hAAAA_0001);
    bus_wr(A_CHAIN, 32'hAAAA_0002);
    bus_wr(A_MODE, 32'hA800_0000);
    bus_rd(A_CHAIN, "R6");

    // 16-word count
    bus_wr(A_MODE, 32'hA843_0000);
    check("R3", {27'b0, word_cnt}, 32'd16);
    for (int i = 0; i < 16; i++) bus_wr(A_CHAIN, 32'h5100_0000 + i);
    for (int i = 0; i < 17; i++) bus_rd(A_CHAIN, "R5");

    // R8 length words, restore order
    bus_wr(A_LO, 32'h0000_0400);
    bus_wr(A_HI, 32'h0000_0001);
    bus_rd(A_LO, "R8");
    bus_rd(A_HI, "R8");

    // R7 busy blocks
    set_busy(1'b1);
    bus_rd(A_STAT, "R7");
    bus_wr(A_CHAIN, 32'hBAD0_0001);
    bus_wr(A_LO, 32'hBAD0_0002);
    bus_wr(A_MODE, 32'h0001_0000);
    bus_rd(A_CHAIN, "R7");
    bus_rd(A_MODE, "R7");
    eng_wr(4'd15, 32'hD16E_5700);
    set_busy(1'b0);
    bus_rd(A_STAT, "R7");
    bus_rd(A_LO, "R7");
    bus_rd(A_MODE, "R7");

    // R9 engine load visible through port
    bus_wr(A_MODE, 32'hA843_0000);
    for (int i = 0; i < 16; i++) bus_rd(A_CHAIN, "R9");

    // R10 unmapped
    bus_wr(12'h010, 32'hFFFF_FFFF);
    bus_rd(12'h010, "R10");
    bus_rd(12'h008, "R10");
    bus_rd(A_MODE, "R10");

    for (int n = 0; n < 3000; n++) begin
      int op;
      op = int'($urandom_range(0, 11));
      case (op)
        0: begin
          bus_wr(A_MODE, {$urandom()} & 32'hFFF8_FFFF
                 | (32'($urandom_range(0, 7)) << 16));
          check("R3", {27'b0, word_cnt}, 32'(exp_cnt(m_mode)));
        end
        1, 2: bus_wr(A_CHAIN, $urandom());
        3, 4: bus_rd(A_CHAIN, "");
        5: bus_wr($urandom_range(0, 1) ? A_LO : A_HI, $urandom());
        6: bus_rd($urandom_range(0, 1) ? A_LO : A_HI, "");
        7: set_busy(($urandom_range(0, 3) == 0) ? 1'b1 : 1'b0);
        8: eng_wr(4'($urandom_range(0, 15)), $urandom());
        9: bus_wr(12'($urandom_range(8, 80)) & 12'hFF8 | 12'h008, $urandom());
        10: bus_rd(A_MODE, "");
        default: bus_rd(A_STAT, "");
      endcase
    end
    set_busy(1'b0);
    bus_rd(A_STAT, "R7");
    finish_run();
  end
endmodule